// File: doc/BRIEF.md
# Trap Context Save and Restore Sequencer

This block runs the multicycle part of trap handling for a 16-bit accumulator processor whose memory is addressed in bytes. When the opcode presented with a start pulse is one of the trapping opcodes, the block reads the top of the system stack from a fixed vector word. It then writes the processor context below that top as a ten-byte frame and fetches the handler address from a second vector word. Last, it hands the new program counter and stack pointer back to the register file. When the opcode is the return-from-trap code, the block walks the same frame upward from the current stack pointer and reloads every saved register.

The memory port moves one byte per cycle and has separate read and write strobes. Read data is taken in the same cycle as the strobe. Words are big-endian: the high byte sits at the lower address. The register values are sampled once, in the cycle the start is accepted. While a sequence runs the block ignores further start pulses. A one-cycle done pulse carries the register load enables, and the new register values are valid during that cycle.

Top module: `trap_ctx_seq`

## Requirements
- R1: After synchronous reset the block is idle: busy, done, both memory strobes and all five load enables are 0.
- R2: A start is acted on only when the opcode is 0x26, 0x27, any value from 0x28 to 0x4F inclusive, or the return code 0x02. Any other opcode leaves the block idle with no memory access and no done.
- R3: Trap entry first reads the stack top T as a big-endian word from the stack vector (0xFFF6 high byte, 0xFFF7 low byte).
- R4: Entry writes the opcode byte to T-1 and four big-endian words below it: the stack pointer at T-3, the program counter at T-5, the index register at T-7 and the accumulator at T-9.
- R5: The byte at T-10 holds the flags in bits 3:0 (N in bit 3, then Z, V, C down to bit 0), with bits 7:4 written as 0.
- R6: Entry ends with the new program counter equal to the big-endian word at 0xFFFE and the new stack pointer equal to T-10. Only the program counter and stack pointer loads are raised.
- R7: Entry makes exactly 14 single-byte accesses, one per cycle, with the read and write strobes never both high. Done rises in the 15th cycle counted from the clock edge that accepts the start, and all ten writes land inside T-10..T-1.
- R8: Return (opcode 0x02) reads nine bytes upward from the stack pointer S. The flags come from bits 3:0 of the byte at S, and bits 7:4 are ignored. The accumulator comes from S+1, the index register from S+3, the program counter from S+5 and the stack pointer from S+7, and address arithmetic wraps at 16 bits. Done and all five load enables rise in the 10th cycle.
- R9: A start that arrives while a sequence is in progress, and any change on the register inputs after acceptance, have no effect on the memory traffic or on the values the sequence produces.
- R10: Done lasts exactly one cycle, and the block is idle and able to accept a new start in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a sequence for `opcode` |
| opcode | input | 8 | Instruction specifier byte of the current instruction |
| reg_a | input | 16 | Current accumulator |
| reg_x | input | 16 | Current index register |
| reg_sp | input | 16 | Current stack pointer |
| reg_pc | input | 16 | Current program counter |
| reg_flags | input | 4 | Current NZVC flags, N in bit 3 |
| mem_addr | output | 16 | Byte address of the current access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the cycle of the read strobe |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_a | output | 1 | Load accumulator from `new_a` |
| ld_x | output | 1 | Load index register from `new_x` |
| ld_sp | output | 1 | Load stack pointer from `new_sp` |
| ld_pc | output | 1 | Load program counter from `new_pc` |
| ld_flags | output | 1 | Load flags from `new_flags` |
| new_a | output | 16 | Restored accumulator |
| new_x | output | 16 | Restored index register |
| new_sp | output | 16 | Stack pointer to load |
| new_pc | output | 16 | Program counter to load |
| new_flags | output | 4 | Restored flags |

## Verification
All 256 opcode values are applied. The 42 trapping codes each run an entry whose stack top, handler address and register values are derived from the opcode. This separates byte-order faults, swapped frame slots, wrong offsets and a missing flags pad from one another. Each entry is followed at once by a return from the frame it built, so any asymmetry between the save order and the restore order shows up as a wrong restored value. Every run also injects a stray start and changes the register inputs in mid-sequence, and the non-trapping codes must produce no memory traffic at all. Separate returns use flags bytes whose upper nibble is set, and one uses a stack pointer close enough to 0xFFFF that the frame reads wrap around to address 0.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    parameter int WORD_W      = 16;
    parameter int BYTE_W      = 8;
    parameter int NZVC_W      = 4;
    parameter int OFS_W       = 5;
    parameter int STEP_W      = 4;
    parameter int FRAME_BYTES = 10;

    localparam int PAD_W = BYTE_W - NZVC_W;
    localparam logic [BYTE_W-1:0] RET_OPCODE = 8'h02;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_ENTRY  = 2'd1,
        MODE_RETURN = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        UOP_READ  = 2'd0,
        UOP_WRITE = 2'd1,
        UOP_END   = 2'd2
    } uop_kind_e;

    typedef enum logic [1:0] {
        BASE_STKVEC = 2'd0,
        BASE_HNDVEC = 2'd1,
        BASE_TOP    = 2'd2,
        BASE_SP     = 2'd3
    } base_e;

    typedef enum logic [3:0] {
        FLD_SPEC  = 4'd0,
        FLD_FLAGS = 4'd1,
        FLD_A_HI  = 4'd2,
        FLD_A_LO  = 4'd3,
        FLD_X_HI  = 4'd4,
        FLD_X_LO  = 4'd5,
        FLD_PC_HI = 4'd6,
        FLD_PC_LO = 4'd7,
        FLD_SP_HI = 4'd8,
        FLD_SP_LO = 4'd9,
        FLD_T_HI  = 4'd10,
        FLD_T_LO  = 4'd11
    } field_e;

    // One step of a sequence: access kind, address base, signed byte offset, data slot
    typedef struct packed {
        uop_kind_e          kind;
        base_e              base;
        logic [OFS_W-1:0]   ofs;
        field_e             field;
    } uop_t;

    // Register snapshot taken when a start is accepted
    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] pc;
        logic [BYTE_W-1:0] spec;
        logic [NZVC_W-1:0] nzvc;
    } ctx_t;

    function automatic logic is_trap_op(input logic [BYTE_W-1:0] op);
        return (op[7:1] == 7'b0010011) || ((op >= 8'h28) && (op <= 8'h4F));
    endfunction

    function automatic logic is_ret_op(input logic [BYTE_W-1:0] op);
        return op == RET_OPCODE;
    endfunction

    function automatic uop_t mk(input uop_kind_e k, input base_e b,
                                input logic [OFS_W-1:0] o, input field_e f);
        uop_t u;
        u.kind  = k;
        u.base  = b;
        u.ofs   = o;
        u.field = f;
        return u;
    endfunction

    // Entry: fetch stack top, push frame downward, fetch handler address.
    // Negative offsets are written in two's complement on OFS_W bits.
    function automatic uop_t entry_uop(input logic [STEP_W-1:0] s);
        case (s)
            4'd0:    return mk(UOP_READ,  BASE_STKVEC, 5'h00, FLD_T_HI);
            4'd1:    return mk(UOP_READ,  BASE_STKVEC, 5'h01, FLD_T_LO);
            4'd2:    return mk(UOP_WRITE, BASE_TOP,    5'h1F, FLD_SPEC);   // T-1
            4'd3:    return mk(UOP_WRITE, BASE_TOP,    5'h1D, FLD_SP_HI);  // T-3
            4'd4:    return mk(UOP_WRITE, BASE_TOP,    5'h1E, FLD_SP_LO);  // T-2
            4'd5:    return mk(UOP_WRITE, BASE_TOP,    5'h1B, FLD_PC_HI);  // T-5
            4'd6:    return mk(UOP_WRITE, BASE_TOP,    5'h1C, FLD_PC_LO);  // T-4
            4'd7:    return mk(UOP_WRITE, BASE_TOP,    5'h19, FLD_X_HI);   // T-7
            4'd8:    return mk(UOP_WRITE, BASE_TOP,    5'h1A, FLD_X_LO);   // T-6
            4'd9:    return mk(UOP_WRITE, BASE_TOP,    5'h17, FLD_A_HI);   // T-9
            4'd10:   return mk(UOP_WRITE, BASE_TOP,    5'h18, FLD_A_LO);   // T-8
            4'd11:   return mk(UOP_WRITE, BASE_TOP,    5'h16, FLD_FLAGS);  // T-10
            4'd12:   return mk(UOP_READ,  BASE_HNDVEC, 5'h00, FLD_PC_HI);
            4'd13:   return mk(UOP_READ,  BASE_HNDVEC, 5'h01, FLD_PC_LO);
            default: return mk(UOP_END,   BASE_SP,     5'h00, FLD_SPEC);
        endcase
    endfunction

    // Return: walk the frame upward from the stack pointer
    function automatic uop_t return_uop(input logic [STEP_W-1:0] s);
        case (s)
            4'd0:    return mk(UOP_READ, BASE_SP, 5'h00, FLD_FLAGS);
            4'd1:    return mk(UOP_READ, BASE_SP, 5'h01, FLD_A_HI);
            4'd2:    return mk(UOP_READ, BASE_SP, 5'h02, FLD_A_LO);
            4'd3:    return mk(UOP_READ, BASE_SP, 5'h03, FLD_X_HI);
            4'd4:    return mk(UOP_READ, BASE_SP, 5'h04, FLD_X_LO);
            4'd5:    return mk(UOP_READ, BASE_SP, 5'h05, FLD_PC_HI);
            4'd6:    return mk(UOP_READ, BASE_SP, 5'h06, FLD_PC_LO);
            4'd7:    return mk(UOP_READ, BASE_SP, 5'h07, FLD_SP_HI);
            4'd8:    return mk(UOP_READ, BASE_SP, 5'h08, FLD_SP_LO);
            default: return mk(UOP_END,  BASE_SP, 5'h00, FLD_SPEC);
        endcase
    endfunction

endpackage

// File: rtl/trap_step_decode.sv
module trap_step_decode
    import trap_seq_pkg::*;
(
    input  mode_e             mode,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);

    always_comb begin
        case (mode)
            MODE_ENTRY:  uop = entry_uop(step);
            MODE_RETURN: uop = return_uop(step);
            default:     uop = mk(UOP_END, BASE_SP, '0, FLD_SPEC);
        endcase
    end

endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
    import trap_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] STACK_VEC   = 16'hFFF6,
    parameter logic [WORD_W-1:0] HANDLER_VEC = 16'hFFFE
) (
    input  base_e             base,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] top,
    input  logic [WORD_W-1:0] sp,
    output logic [WORD_W-1:0] addr
);

    localparam int EXT_W = WORD_W - OFS_W;

    logic [WORD_W-1:0] base_val;
    logic [WORD_W-1:0] ofs_ext;

    always_comb begin
        case (base)
            BASE_STKVEC: base_val = STACK_VEC;
            BASE_HNDVEC: base_val = HANDLER_VEC;
            BASE_TOP:    base_val = top;
            default:     base_val = sp;
        endcase
    end

    assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    assign addr    = base_val + ofs_ext;   // wraps modulo 2^WORD_W

endmodule

// File: rtl/trap_ctx_store.sv
module trap_ctx_store
    import trap_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  ctx_t              ctx_in,
    input  logic              rd_en,
    input  field_e            field,
    input  logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] snap_sp,
    output logic [WORD_W-1:0] top,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_x,
    output logic [WORD_W-1:0] res_sp,
    output logic [WORD_W-1:0] res_pc,
    output logic [NZVC_W-1:0] res_nzvc
);

    ctx_t snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap     <= '0;
            top      <= '0;
            res_a    <= '0;
            res_x    <= '0;
            res_sp   <= '0;
            res_pc   <= '0;
            res_nzvc <= '0;
        end else begin
            if (capture) snap <= ctx_in;
            if (rd_en) begin
                case (field)
                    FLD_T_HI:  top[WORD_W-1 -: BYTE_W]    <= rdata;
                    FLD_T_LO:  top[BYTE_W-1:0]            <= rdata;
                    FLD_A_HI:  res_a[WORD_W-1 -: BYTE_W]  <= rdata;
                    FLD_A_LO:  res_a[BYTE_W-1:0]          <= rdata;
                    FLD_X_HI:  res_x[WORD_W-1 -: BYTE_W]  <= rdata;
                    FLD_X_LO:  res_x[BYTE_W-1:0]          <= rdata;
                    FLD_PC_HI: res_pc[WORD_W-1 -: BYTE_W] <= rdata;
                    FLD_PC_LO: res_pc[BYTE_W-1:0]         <= rdata;
                    FLD_SP_HI: res_sp[WORD_W-1 -: BYTE_W] <= rdata;
                    FLD_SP_LO: res_sp[BYTE_W-1:0]         <= rdata;
                    FLD_FLAGS: res_nzvc                   <= rdata[NZVC_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (field)
            FLD_SPEC:  wdata = snap.spec;
            FLD_FLAGS: wdata = {{PAD_W{1'b0}}, snap.nzvc};
            FLD_A_HI:  wdata = snap.a[WORD_W-1 -: BYTE_W];
            FLD_A_LO:  wdata = snap.a[BYTE_W-1:0];
            FLD_X_HI:  wdata = snap.x[WORD_W-1 -: BYTE_W];
            FLD_X_LO:  wdata = snap.x[BYTE_W-1:0];
            FLD_PC_HI: wdata = snap.pc[WORD_W-1 -: BYTE_W];
            FLD_PC_LO: wdata = snap.pc[BYTE_W-1:0];
            FLD_SP_HI: wdata = snap.sp[WORD_W-1 -: BYTE_W];
            FLD_SP_LO: wdata = snap.sp[BYTE_W-1:0];
            default:   wdata = '0;
        endcase
    end

    assign snap_sp = snap.sp;

    // R4: the frame base only moves when one of its bytes is read
    assert_top_held_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && (field == FLD_T_HI || field == FLD_T_LO)) |=> $stable(top));

    // R9: the snapshot only moves on an accepted start
    assert_snap_held_R9: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(snap));

endmodule

// File: rtl/trap_ctx_seq.sv
module trap_ctx_seq
    import trap_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] STACK_VEC   = 16'hFFF6,
    parameter logic [WORD_W-1:0] HANDLER_VEC = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [WORD_W-1:0] reg_a,
    input  logic [WORD_W-1:0] reg_x,
    input  logic [WORD_W-1:0] reg_sp,
    input  logic [WORD_W-1:0] reg_pc,
    input  logic [NZVC_W-1:0] reg_flags,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              ld_a,
    output logic              ld_x,
    output logic              ld_sp,
    output logic              ld_pc,
    output logic              ld_flags,
    output logic [WORD_W-1:0] new_a,
    output logic [WORD_W-1:0] new_x,
    output logic [WORD_W-1:0] new_sp,
    output logic [WORD_W-1:0] new_pc,
    output logic [NZVC_W-1:0] new_flags
);

    mode_e             mode_q;
    logic [STEP_W-1:0] step_q;
    uop_t              uop;
    logic              accept_trap;
    logic              accept_ret;
    logic              capture;
    ctx_t              ctx_in;
    logic [WORD_W-1:0] top;
    logic [WORD_W-1:0] snap_sp;
    logic [WORD_W-1:0] res_sp;

    assign accept_trap = (mode_q == MODE_IDLE) && start && is_trap_op(opcode);
    assign accept_ret  = (mode_q == MODE_IDLE) && start && is_ret_op(opcode);
    assign capture     = accept_trap || accept_ret;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE;
            step_q <= '0;
        end else if (mode_q == MODE_IDLE) begin
            step_q <= '0;
            if (accept_trap)     mode_q <= MODE_ENTRY;
            else if (accept_ret) mode_q <= MODE_RETURN;
        end else if (uop.kind == UOP_END) begin
            mode_q <= MODE_IDLE;
            step_q <= '0;
        end else begin
            step_q <= step_q + 1'b1;
        end
    end

    trap_step_decode u_decode (
        .mode (mode_q),
        .step (step_q),
        .uop  (uop)
    );

    assign ctx_in = '{a: reg_a, x: reg_x, sp: reg_sp, pc: reg_pc,
                      spec: opcode, nzvc: reg_flags};

    trap_ctx_store u_store (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .ctx_in   (ctx_in),
        .rd_en    (mem_rd),
        .field    (uop.field),
        .rdata    (mem_rdata),
        .wdata    (mem_wdata),
        .snap_sp  (snap_sp),
        .top      (top),
        .res_a    (new_a),
        .res_x    (new_x),
        .res_sp   (res_sp),
        .res_pc   (new_pc),
        .res_nzvc (new_flags)
    );

    trap_addr_gen #(
        .STACK_VEC   (STACK_VEC),
        .HANDLER_VEC (HANDLER_VEC)
    ) u_addr (
        .base (uop.base),
        .ofs  (uop.ofs),
        .top  (top),
        .sp   (snap_sp),
        .addr (mem_addr)
    );

    assign busy     = (mode_q != MODE_IDLE);
    assign mem_rd   = busy && (uop.kind == UOP_READ);
    assign mem_wr   = busy && (uop.kind == UOP_WRITE);
    assign done     = busy && (uop.kind == UOP_END);
    assign ld_pc    = done;
    assign ld_sp    = done;
    assign ld_a     = done && (mode_q == MODE_RETURN);
    assign ld_x     = done && (mode_q == MODE_RETURN);
    assign ld_flags = done && (mode_q == MODE_RETURN);
    assign new_sp   = (mode_q == MODE_ENTRY) ? (top - WORD_W'(FRAME_BYTES)) : res_sp;

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !mem_wr);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_vector_first_R3: assert property (@(posedge clk) disable iff (rst)
        accept_trap |=> (mem_rd && mem_addr == STACK_VEC));

    assert_frame_base_R8: assert property (@(posedge clk) disable iff (rst)
        accept_ret |=> (mem_rd && mem_addr == $past(reg_sp)));

    assert_runs_to_end_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && step_q == $past(step_q) + 1'b1));

    assert_write_on_entry_R4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mode_q == MODE_ENTRY));

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && (is_trap_op(opcode) || is_ret_op(opcode)))) |=> !busy);

endmodule

// File: tb/sim_trap_ctx_seq.sv
module sim_trap_ctx_seq;

    // Default time unit is 1 ps: half period 2500 gives a 200 MHz clock
    logic        clk = 1'b0;
    always #2500 clk = ~clk;

    logic        rst;
    logic        start;
    logic [7:0]  opcode;
    logic [15:0] reg_a, reg_x, reg_sp, reg_pc;
    logic [3:0]  reg_flags;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, ld_a, ld_x, ld_sp, ld_pc, ld_flags;
    logic [15:0] new_a, new_x, new_sp, new_pc;
    logic [3:0]  new_flags;

    int checks = 0;
    int fails  = 0;
    int wr_count;
    int wr_bad;
    logic [15:0] exp_base;
    logic [7:0]  mem [0:1023];

    trap_ctx_seq u0 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .reg_a(reg_a), .reg_x(reg_x), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .reg_flags(reg_flags), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ld_a(ld_a), .ld_x(ld_x), .ld_sp(ld_sp),
        .ld_pc(ld_pc), .ld_flags(ld_flags), .new_a(new_a), .new_x(new_x),
        .new_sp(new_sp), .new_pc(new_pc), .new_flags(new_flags)
    );

    // Byte memory model, aliased on the low 10 address bits
    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_count = wr_count + 1;
            if (16'(mem_addr - exp_base) > 16'd9) wr_bad = wr_bad + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd16(input logic [15:0] a);
        logic [15:0] b;
        b = a + 16'd1;
        return {mem[a[9:0]], mem[b[9:0]]};
    endfunction

    function automatic logic [7:0] rd8(input logic [15:0] a);
        return mem[a[9:0]];
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Return sequence from stack pointer spv; expected values given by caller
    task automatic run_return(input logic [15:0] spv, input logic [15:0] ea,
                              input logic [15:0] ex, input logic [15:0] epc,
                              input logic [15:0] esp, input logic [3:0] efl,
                              input string what);
        int n;
        @(negedge clk);
        start = 1'b1; opcode = 8'h02; reg_sp = spv;
        reg_a = 16'h5A5A; reg_x = 16'hA5A5; reg_pc = 16'h7777; reg_flags = 4'h6;
        @(posedge clk); #500;
        start = 1'b0; n = 1;
        while (!done && n < 40) begin
            @(posedge clk); #500; n++;
            if (n == 3) begin
                start = 1'b1; opcode = 8'h30; reg_sp = 16'h0BAD;
            end else start = 1'b0;
        end
        chk(n == 10, "R8", {what, " return cycles"}, n, 10);
        chk(ld_a && ld_x && ld_sp && ld_pc && ld_flags, "R8", {what, " return loads"},
            {ld_a, ld_x, ld_sp, ld_pc, ld_flags}, 5'b11111);
        chk(new_a == ea, "R8", {what, " accumulator"}, new_a, ea);
        chk(new_x == ex, "R8", {what, " index"}, new_x, ex);
        chk(new_pc == epc, "R8", {what, " program counter"}, new_pc, epc);
        chk(new_sp == esp, "R8", {what, " stack pointer"}, new_sp, esp);
        chk(new_flags == efl, "R8", {what, " flags"}, new_flags, efl);
        @(posedge clk); #500;
        chk(!done && !busy, "R10", {what, " idle after return"}, {done, busy}, 0);
    endtask

    task automatic run_entry(input logic [7:0] op);
        logic [15:0] t, hv, va, vx, vsp, vpc;
        logic [3:0]  vf;
        int n;
        t   = {op[7:2], 10'h000} + 16'h0100 + 16'({op[5:0], 3'b000});
        hv  = {op, ~op};
        va  = {~op, op};
        vx  = 16'h1234 + 16'(op);
        vsp = 16'hF000 - 16'(op);
        vpc = 16'h0100 + 16'(op) * 16'd3;
        vf  = op[3:0] ^ 4'h9;
        mem[10'h3F6] = t[15:8];  mem[10'h3F7] = t[7:0];
        mem[10'h3FE] = hv[15:8]; mem[10'h3FF] = hv[7:0];
        exp_base = t - 16'd10; wr_count = 0; wr_bad = 0;
        @(negedge clk);
        start = 1'b1; opcode = op;
        reg_a = va; reg_x = vx; reg_sp = vsp; reg_pc = vpc; reg_flags = vf;
        @(posedge clk); #500;
        start = 1'b0; n = 1;
        while (!done && n < 40) begin
            @(posedge clk); #500; n++;
            if (n == 3) begin
                start = 1'b1; opcode = 8'h02;
                reg_a = 16'hDEAD; reg_x = 16'hBEEF; reg_sp = 16'h0BAD;
                reg_pc = 16'hF00D; reg_flags = 4'hF;
            end else start = 1'b0;
        end
        chk(n == 15, "R7", "entry cycles", n, 15);
        chk(ld_pc && ld_sp && !ld_a && !ld_x && !ld_flags, "R6", "entry loads",
            {ld_a, ld_x, ld_sp, ld_pc, ld_flags}, 5'b00110);
        chk(new_pc == hv, "R6", "handler address", new_pc, hv);
        chk(new_sp == t - 16'd10, "R3", "stack top read big-endian", new_sp, t - 16'd10);
        @(posedge clk); #500;
        chk(!done && !busy, "R10", "idle after entry", {done, busy}, 0);
        chk(rd8(t - 16'd1) == op, "R4", "specifier byte", rd8(t - 16'd1), op);
        chk(rd16(t - 16'd3) == vsp, "R4", "saved SP", rd16(t - 16'd3), vsp);
        chk(rd16(t - 16'd5) == vpc, "R4", "saved PC", rd16(t - 16'd5), vpc);
        chk(rd16(t - 16'd7) == vx, "R4", "saved X", rd16(t - 16'd7), vx);
        chk(rd16(t - 16'd9) == va, "R9", "saved A despite input change", rd16(t - 16'd9), va);
        chk(rd8(t - 16'd10) == {4'h0, vf}, "R5", "flags byte", rd8(t - 16'd10), {4'h0, vf});
        chk(wr_count == 10 && wr_bad == 0, "R7", "write count and range",
            {wr_count[15:0], wr_bad[15:0]}, {16'd10, 16'd0});
        exp_base = 16'h0000;
        run_return(t - 16'd10, va, vx, vpc, vsp, vf, "round trip");
    endtask

    task automatic run_ignored(input logic [7:0] op);
        logic seen;
        seen = 1'b0;
        @(negedge clk);
        start = 1'b1; opcode = op;
        @(posedge clk); #500;
        start = 1'b0;
        seen = seen | busy | mem_rd | mem_wr | done;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #500;
            seen = seen | busy | mem_rd | mem_wr | done;
        end
        chk(!seen, "R2", $sformatf("opcode %02h ignored", op), seen, 0);
    endtask

    task automatic run_direct_return(input logic [15:0] spv, input int k);
        logic [15:0] a, x, pc, sp, p;
        logic [3:0]  fl;
        a  = 16'h8000 + 16'(k) * 16'h0111;
        x  = 16'h00FF - 16'(k);
        pc = 16'h0001 + 16'(k) * 16'h1000;
        sp = 16'hFB8F - 16'(k);
        fl = 4'(k * 3 + 1);
        p  = spv;
        mem[p[9:0]] = {4'(4'hF - 4'(k)) | 4'h8, fl};   // upper nibble set, must be ignored
        p = spv + 16'd1; mem[p[9:0]] = a[15:8];
        p = spv + 16'd2; mem[p[9:0]] = a[7:0];
        p = spv + 16'd3; mem[p[9:0]] = x[15:8];
        p = spv + 16'd4; mem[p[9:0]] = x[7:0];
        p = spv + 16'd5; mem[p[9:0]] = pc[15:8];
        p = spv + 16'd6; mem[p[9:0]] = pc[7:0];
        p = spv + 16'd7; mem[p[9:0]] = sp[15:8];
        p = spv + 16'd8; mem[p[9:0]] = sp[7:0];
        run_return(spv, a, x, pc, sp, fl, "direct");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R7 watchdog expired: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        wr_count = 0; wr_bad = 0; exp_base = 16'h0000;
        rst = 1'b1; start = 1'b0; opcode = 8'h00;
        reg_a = '0; reg_x = '0; reg_sp = '0; reg_pc = '0; reg_flags = '0;
        repeat (4) @(posedge clk);
        #500;
        rst = 1'b0;
        chk(!busy && !done && !mem_rd && !mem_wr &&
            !(ld_a | ld_x | ld_sp | ld_pc | ld_flags), "R1", "reset state",
            {busy, done, mem_rd, mem_wr, ld_a, ld_x, ld_sp, ld_pc, ld_flags}, 0);
        for (int op = 0; op < 256; op++) begin
            logic [7:0] o;
            o = 8'(op);
            if (o == 8'h02) run_direct_return(16'h2210, 0);
            else if (o[7:1] == 7'b0010011 || (o >= 8'h28 && o <= 8'h4F)) run_entry(o);
            else run_ignored(o);
        end
        for (int k = 1; k < 6; k++) run_direct_return(16'h0140 + 16'(k) * 16'd23, k);
        run_direct_return(16'hFFFC, 6);   // frame reads wrap past 0xFFFF
        summary();
        $finish;
    end

endmodule